// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

A 2048-byte memory with two independent ports on one shared clock, for message passing between two processors. Each side has an 11-bit address, an active-low select, an active-low output enable, an active-low write strobe, a write byte and a busy input. All controls are sampled as synchronous strobes. Read data is registered and appears one cycle after the address, together with a valid bit.

The two top locations are doorbells. The left side owns address 0x7FE and the right side owns 0x7FF. When one side writes the mailbox owned by the other side, that side's active-low interrupt output goes low. The interrupt stays low until the owner accesses its own mailbox with select and output enable both low. The mailbox bytes are still plain storage, so the doorbell write can carry a message byte.

A low busy input on a port blocks that port's memory writes, flag sets and flag clears. Reads are not affected.

Top module: `mailbox_dpram`

## Requirements
- R1: While reset is held and just after it is released, both interrupt outputs are high, both valid outputs are low and both read buses are zero.
- R2: A port writes its data byte when select and write strobe are both low and busy is high. A port reads when select and output enable are low and the write strobe is high. The stored byte and a high valid then appear on the next cycle.
- R3: On any cycle that is not a read (deselected, writing, or output enable high), the port's read bus is all zeros on the next cycle and its valid is low.
- R4: A write attempted while that port's busy input is low leaves the addressed location unchanged.
- R5: A right-port write to address 0x7FE drives the left interrupt output low on the next cycle.
- R6: A left-port write to address 0x7FF drives the right interrupt output low on the next cycle.
- R7: A low interrupt returns high on the next cycle after the owning port accesses its own mailbox (left 0x7FE, right 0x7FF) with select and output enable low. This holds whatever the write strobe level is.
- R8: A set or clear attempted by a port whose busy input is low leaves the flag unchanged.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (interrupt low).
- R10: The mailbox bytes read back whatever value was last written to them.
- R11: When both ports write the same address in the same cycle, the left port's byte is kept.
- R12: A read that meets a write from the other port at the same address in the same cycle returns the old byte.
- R13: A port writing its own mailbox does not raise its own interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_n | input | 1 | Left busy, low blocks writes and flag changes |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write byte |
| l_rdata | output | 8 | Left read byte, zero when not reading |
| l_rvalid | output | 1 | Left read valid |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_n | input | 1 | Right busy, low blocks writes and flag changes |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write byte |
| r_rdata | output | 8 | Right read byte, zero when not reading |
| r_rvalid | output | 1 | Right read valid |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check several rules on every cycle:
- each flag follows its set and clear strobes, with set winning a tie;
- a flag holds when there is neither set nor clear;
- a non-read cycle leaves zeros and a low valid;
- a read cycle yields valid on the next cycle;
- a busy peer cannot ring the doorbell.

Other behaviours depend on the stored contents, so only the bench's scenarios can show them:
- the byte actually returned;
- a busy write leaving memory unchanged;
- the left side winning a same-address write collision;
- read-old behaviour against a concurrent write;
- the mailbox bytes keeping their message.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // which side keeps its byte on a same-address write collision
   typedef enum logic {WIN_LEFT = 1'b0, WIN_RIGHT = 1'b1} collide_e;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
   parameter int ADDR_W   = 11,
   parameter int OWN_MBX  = 2046,
   parameter int PEER_MBX = 2047
) (
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              busy_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic              rd_en,
   output logic              ring_peer,
   output logic              ack_own
);
   localparam logic [ADDR_W-1:0] OwnA  = ADDR_W'(OWN_MBX);
   localparam logic [ADDR_W-1:0] PeerA = ADDR_W'(PEER_MBX);

   always_comb begin
      wr_en     = !cs_n && !we_n && busy_n;
      rd_en     = !cs_n && !oe_n && we_n;
      ring_peer = wr_en && (addr == PeerA);
      // owner access with select and output enable low, write strobe ignored
      ack_own   = !cs_n && !oe_n && busy_n && (addr == OwnA);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_n_o
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend <= 1'b0;
      else if (set_i) pend <= 1'b1;
      else if (clr_i) pend <= 1'b0;
   end

   assign irq_n_o = ~pend;

   assert_set_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> !irq_n_o);
   assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> !irq_n_o);
   assert_clear_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> irq_n_o);
   assert_flag_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbx_store.sv
module mbx_store
   import mbx_pkg::*;
#(
   parameter int       ADDR_W = 11,
   parameter int       DATA_W = 8,
   parameter collide_e WINNER = WIN_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_wr,
   input  logic              l_rd,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wd,
   output logic [DATA_W-1:0] l_rd_q,
   output logic              l_vld_q,
   input  logic              r_wr,
   input  logic              r_rd,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wd,
   output logic [DATA_W-1:0] r_rd_q,
   output logic              r_vld_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic clash, l_go, r_go;

   assign clash = l_wr && r_wr && (l_addr == r_addr);

   generate
      if (WINNER == WIN_LEFT) begin : g_left_wins
         assign l_go = l_wr;
         assign r_go = r_wr && !clash;
      end else begin : g_right_wins
         assign l_go = l_wr && !clash;
         assign r_go = r_wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (l_go) mem[l_addr] <= l_wd;
      if (r_go) mem[r_addr] <= r_wd;
   end

   // registered reads see the array before this edge's writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_rd_q  <= '0;
         l_vld_q <= 1'b0;
         r_rd_q  <= '0;
         r_vld_q <= 1'b0;
      end else begin
         l_rd_q  <= l_rd ? mem[l_addr] : '0;
         l_vld_q <= l_rd;
         r_rd_q  <= r_rd ? mem[r_addr] : '0;
         r_vld_q <= r_rd;
      end
   end

   assert_left_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rd |=> (l_rd_q == '0 && !l_vld_q));
   assert_right_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rd |=> (r_rd_q == '0 && !r_vld_q));
   assert_left_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      l_rd |=> l_vld_q);
   assert_right_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      r_rd |=> r_vld_q);
endmodule

// File: rtl/mailbox_dpram.sv
module mailbox_dpram
   import mbx_pkg::*;
#(
   parameter int       ADDR_W = 11,
   parameter int       DATA_W = 8,
   parameter collide_e WINNER = WIN_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_cs_n,
   input  logic              l_oe_n,
   input  logic              l_we_n,
   input  logic              l_busy_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   output logic              l_irq_n,
   input  logic              r_cs_n,
   input  logic              r_oe_n,
   input  logic              r_we_n,
   input  logic              r_busy_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   output logic              r_irq_n
);
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int L_MAILBX = DEPTH - 2;
   localparam int R_MAILBX = DEPTH - 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
         $error("mailbox_dpram: ADDR_W must lie in 2..16");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mailbox_dpram: DATA_W must be at least 1");
      end
   endgenerate

   logic l_wr, l_rd, l_ring, l_ack;
   logic r_wr, r_rd, r_ring, r_ack;

   mbx_port_dec #(.ADDR_W(ADDR_W), .OWN_MBX(L_MAILBX), .PEER_MBX(R_MAILBX)) u_dec_l (
      .cs_n(l_cs_n), .oe_n(l_oe_n), .we_n(l_we_n), .busy_n(l_busy_n), .addr(l_addr),
      .wr_en(l_wr), .rd_en(l_rd), .ring_peer(l_ring), .ack_own(l_ack));

   mbx_port_dec #(.ADDR_W(ADDR_W), .OWN_MBX(R_MAILBX), .PEER_MBX(L_MAILBX)) u_dec_r (
      .cs_n(r_cs_n), .oe_n(r_oe_n), .we_n(r_we_n), .busy_n(r_busy_n), .addr(r_addr),
      .wr_en(r_wr), .rd_en(r_rd), .ring_peer(r_ring), .ack_own(r_ack));

   mbx_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINNER(WINNER)) u_store (
      .clk(clk), .rst_n(rst_n),
      .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wd(l_wdata),
      .l_rd_q(l_rdata), .l_vld_q(l_rvalid),
      .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wd(r_wdata),
      .r_rd_q(r_rdata), .r_vld_q(r_rvalid));

   // the peer rings, the owner acknowledges
   mbx_flag u_flag_l (.clk(clk), .rst_n(rst_n), .set_i(r_ring), .clr_i(l_ack), .irq_n_o(l_irq_n));
   mbx_flag u_flag_r (.clk(clk), .rst_n(rst_n), .set_i(l_ring), .clr_i(r_ack), .irq_n_o(r_irq_n));

   assert_busy_blocks_left_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_busy_n && l_irq_n) |=> l_irq_n);
   assert_busy_blocks_right_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_busy_n && r_irq_n) |=> r_irq_n);
   assert_busy_blocks_left_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_busy_n && !l_irq_n) |=> !l_irq_n);
   assert_busy_blocks_right_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_busy_n && !r_irq_n) |=> !r_irq_n);
endmodule

// File: tb/mailbox_dpram_test.sv
`timescale 1ns/100ps
module mailbox_dpram_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_cs_n = 1, l_oe_n = 1, l_we_n = 1, l_busy_n = 1;
   logic r_cs_n = 1, r_oe_n = 1, r_we_n = 1, r_busy_n = 1;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wdata = '0, r_wdata = '0;
   logic [7:0]  l_rdata, r_rdata;
   logic        l_rvalid, r_rvalid, l_irq_n, r_irq_n;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   mailbox_dpram uut (.*);

   // behavioural reference model
   logic [7:0] mdl [int];
   logic [7:0] e_lrd = 0, e_rrd = 0;
   logic e_lv = 0, e_rv = 0, e_lirq = 1, e_rirq = 1;

   always @(posedge clk) begin
      bit lw, rw, lr, rr, lset, lclr, rset, rclr;
      if (!rst_n) begin
         e_lrd = 0; e_rrd = 0; e_lv = 0; e_rv = 0; e_lirq = 1; e_rirq = 1;
      end else begin
         lw = !l_cs_n && !l_we_n && l_busy_n;
         rw = !r_cs_n && !r_we_n && r_busy_n;
         lr = !l_cs_n && !l_oe_n && l_we_n;
         rr = !r_cs_n && !r_oe_n && r_we_n;
         e_lrd = (lr && mdl.exists(int'(l_addr))) ? mdl[int'(l_addr)] : 8'h00;
         e_rrd = (rr && mdl.exists(int'(r_addr))) ? mdl[int'(r_addr)] : 8'h00;
         e_lv = lr; e_rv = rr;
         if (rw) mdl[int'(r_addr)] = r_wdata;
         if (lw) mdl[int'(l_addr)] = l_wdata;
         lset = rw && r_addr == 11'h7FE;
         lclr = !l_cs_n && !l_oe_n && l_busy_n && l_addr == 11'h7FE;
         rset = lw && l_addr == 11'h7FF;
         rclr = !r_cs_n && !r_oe_n && r_busy_n && r_addr == 11'h7FF;
         if (lset) e_lirq = 0; else if (lclr) e_lirq = 1;
         if (rset) e_rirq = 0; else if (rclr) e_rirq = 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model comparison on every cycle
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(l_rdata == e_lrd, cur_req, l_rdata, e_lrd);
         chk(r_rdata == e_rrd, cur_req, r_rdata, e_rrd);
         chk(l_rvalid == e_lv, cur_req, l_rvalid, e_lv);
         chk(r_rvalid == e_rv, cur_req, r_rvalid, e_rv);
         chk(l_irq_n == e_lirq, cur_req, l_irq_n, e_lirq);
         chk(r_irq_n == e_rirq, cur_req, r_irq_n, e_rirq);
      end
   end

   task automatic lp(input logic cs, oe, we, input logic [10:0] a, input logic [7:0] d, input logic bz);
      l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_addr = a; l_wdata = d; l_busy_n = bz;
   endtask
   task automatic rp(input logic cs, oe, we, input logic [10:0] a, input logic [7:0] d, input logic bz);
      r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_addr = a; r_wdata = d; r_busy_n = bz;
   endtask
   task automatic idle();
      lp(1, 1, 1, 0, 0, 1); rp(1, 1, 1, 0, 0, 1);
   endtask
   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(l_irq_n && r_irq_n, "R1", {l_irq_n, r_irq_n}, 3);
      chk(!l_rvalid && !r_rvalid && l_rdata == 0 && r_rdata == 0, "R1", {l_rvalid, r_rvalid}, 0);
      rst_n = 1;
      step();
      chk(l_irq_n && r_irq_n && !l_rvalid, "R1", {l_irq_n, r_irq_n}, 3);

      cur_req = "R2";
      lp(0, 1, 0, 11'h005, 8'h3C, 1); step();
      idle(); rp(0, 0, 1, 11'h005, 0, 1); lp(0, 0, 1, 11'h005, 0, 1); step();
      chk(r_rdata == 8'h3C && r_rvalid, "R2", r_rdata, 8'h3C);
      chk(l_rdata == 8'h3C && l_rvalid, "R2", l_rdata, 8'h3C);

      cur_req = "R3";
      rp(1, 0, 1, 11'h005, 0, 1); lp(0, 1, 1, 11'h005, 0, 1); step();
      chk(r_rdata == 0 && !r_rvalid, "R3", r_rdata, 0);
      chk(l_rdata == 0 && !l_rvalid, "R3", l_rdata, 0);

      cur_req = "R4";
      idle(); lp(0, 1, 0, 11'h006, 8'h11, 1); step();
      lp(0, 1, 0, 11'h006, 8'h99, 0); step();
      lp(0, 0, 1, 11'h006, 0, 1); step();
      chk(l_rdata == 8'h11, "R4", l_rdata, 8'h11);

      cur_req = "R13";
      idle(); lp(0, 1, 0, 11'h7FE, 8'h0F, 1); step();
      chk(l_irq_n == 1, "R13", l_irq_n, 1);

      cur_req = "R5";
      idle(); rp(0, 1, 0, 11'h7FE, 8'hA5, 1); step();
      chk(l_irq_n == 0, "R5", l_irq_n, 0);

      cur_req = "R10";
      idle(); lp(0, 0, 1, 11'h7FE, 0, 1); step();
      chk(l_rdata == 8'hA5, "R10", l_rdata, 8'hA5);
      chk(l_irq_n == 1, "R7", l_irq_n, 1);

      cur_req = "R6";
      idle(); lp(0, 1, 0, 11'h7FF, 8'h5A, 1); step();
      chk(r_irq_n == 0, "R6", r_irq_n, 0);

      cur_req = "R8";
      idle(); rp(0, 0, 1, 11'h7FF, 0, 0); step();
      chk(r_irq_n == 0, "R8", r_irq_n, 0);

      cur_req = "R7";
      idle(); rp(0, 0, 0, 11'h7FF, 8'h77, 1); step();
      chk(r_irq_n == 1, "R7", r_irq_n, 1);
      idle(); rp(0, 0, 1, 11'h7FF, 0, 1); step();
      chk(r_rdata == 8'h77, "R10", r_rdata, 8'h77);

      cur_req = "R8";
      idle(); rp(0, 1, 0, 11'h7FE, 8'hEE, 0); step();
      chk(l_irq_n == 1, "R8", l_irq_n, 1);

      cur_req = "R9";
      idle(); rp(0, 1, 0, 11'h7FE, 8'h42, 1); lp(0, 0, 1, 11'h7FE, 0, 1); step();
      chk(l_irq_n == 0, "R9", l_irq_n, 0);
      chk(l_rdata == 8'hA5, "R12", l_rdata, 8'hA5);
      idle(); lp(0, 0, 1, 11'h7FE, 0, 1); step();
      chk(l_rdata == 8'h42 && l_irq_n, "R9", l_rdata, 8'h42);

      cur_req = "R11";
      idle(); lp(0, 1, 0, 11'h010, 8'h01, 1); rp(0, 1, 0, 11'h010, 8'h02, 1); step();
      idle(); rp(0, 0, 1, 11'h010, 0, 1); step();
      chk(r_rdata == 8'h01, "R11", r_rdata, 8'h01);

      cur_req = "R12";
      idle(); lp(0, 1, 0, 11'h020, 8'h44, 1); step();
      lp(0, 1, 0, 11'h020, 8'h55, 1); rp(0, 0, 1, 11'h020, 0, 1); step();
      chk(r_rdata == 8'h44, "R12", r_rdata, 8'h44);
      idle(); rp(0, 0, 1, 11'h020, 0, 1); step();
      chk(r_rdata == 8'h55, "R12", r_rdata, 8'h55);

      idle(); step();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule